// File: doc/BRIEF.md
# Manchester Transmit Encoder

This block turns a serial NRZ bit stream into a Manchester-coded line signal for a 10 Mb/s Ethernet-style link. It runs from a single reference clock, nominally 20 MHz. It divides that clock to form a bit-rate clock, nominally 10 MHz. Both halves of every bit cell take their timing from the reference clock.

The transmit enable and the data bit are resynchronised at each bit-cell boundary. The block then drives an output pair, modelled as two logic legs. While enable is held, every sampled bit is sent as a pair of opposite half-cells. When enable is removed, the bit in flight is completed and the pair settles into one of two idle states, chosen by a one-bit select input:

- **Zero differential:** both legs low.
- **Logic-high differential:** positive leg high, negative leg low.

The divided bit clock is exported so that a receive section can use it as its reference while the line is quiet. Parameter `REF_PER_BIT` sets the number of reference cycles per bit cell. Parameter `OUT_REG` adds an optional output register stage.

Top module: `manchester_tx_enc`

## Requirements
- R1: While `rst_n` is low, `line_p`, `line_n` and `bit_clk` are all 0.
- R2: `bit_clk` has a period of `REF_PER_BIT` reference cycles. It is 0 in the first half of each bit cell and 1 in the second half, so a falling edge of `bit_clk` marks the start of a cell.
- R3: For an active cell, the bit value is carried by the direction of the transition at mid-cell:
  - A 0 drives `line_p` high in the first half-cell and low in the second.
  - A 1 drives `line_p` low in the first half-cell and high in the second.
- R4: In every active half-cell, `line_n` is the inverse of `line_p`.
- R5: `tx_en` and `tx_data` are sampled only on the reference edge that begins a cell. A value present at that edge is encoded in the cell that follows (the first half appears right after the edge). Changes at any other time do not affect the cell in progress.
- R6: If `tx_en` falls part way through a cell, that cell still completes both of its halves with the sampled bit. The idle state begins with the next cell.
- R7: When the sampled enable is 0 and the sampled idle select is 0, `line_p` and `line_n` are both 0.
- R8: When the sampled enable is 0 and the sampled idle select is 1, `line_p` is 1 and `line_n` is 0, and they hold steady for as long as the line stays idle.
- R9: `idle_hi_sel` is sampled at cell boundaries only:
  - Toggling it while the line is active leaves the encoded bits unchanged.
  - Toggling it within an idle cell takes effect from the next cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (20 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable, sampled at each cell boundary |
| tx_data | input | 1 | NRZ data bit, sampled at each cell boundary |
| idle_hi_sel | input | 1 | Idle state select: 0 gives zero differential, 1 gives logic-high differential |
| line_p | output | 1 | Positive leg of the line pair |
| line_n | output | 1 | Negative leg of the line pair |
| bit_clk | output | 1 | Divided bit-rate clock for a receive section |

## Verification
The encoder is driven with three data patterns:

- **Alternating 1010:** every cell polarity flips, which exposes a swapped half-cell order.
- **Runs of zeros:** the transition direction repeats, which exposes a missing or misplaced mid-cell edge.
- **Runs of ones:** same purpose as the runs of zeros, for the opposite polarity.

Enable and data are changed inside a cell to show that only cell-boundary values matter and that a dropped enable still completes its bit. Both idle levels are exercised. The idle select is toggled during traffic and inside an idle cell, to tell boundary sampling apart from a direct, unsampled path.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

   typedef struct packed {
      logic p;
      logic n;
   } mtx_line_t;

   // Level of the pair when no bit is being sent.
   function automatic mtx_line_t mtx_idle_level(input logic hi_sel);
      mtx_line_t v;
      v.p = hi_sel;
      v.n = 1'b0;
      return v;
   endfunction

   // Level of the pair for one half of an active cell.
   // A 0 bit goes high then low; a 1 bit goes low then high.
   function automatic mtx_line_t mtx_half_level(input logic bit_v, input logic first_half);
      mtx_line_t v;
      v.p = first_half ? ~bit_v : bit_v;
      v.n = ~v.p;
      return v;
   endfunction

endpackage

// File: rtl/mtx_bitclk_div.sv
module mtx_bitclk_div #(
   parameter int REF_PER_BIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic cell_start_o,
   output logic mid_o,
   output logic first_half_o,
   output logic bit_clk_o
);
   localparam int HALF = REF_PER_BIT / 2;
   localparam int CW   = (REF_PER_BIT > 2) ? $clog2(REF_PER_BIT) : 1;
   localparam logic [CW-1:0] LAST    = CW'(REF_PER_BIT - 1);
   localparam logic [CW-1:0] MID_CNT = CW'(HALF - 1);
   localparam logic [CW-1:0] HALF_CNT = CW'(HALF);

   if (REF_PER_BIT < 2 || (REF_PER_BIT % 2) != 0) begin : g_bad_ratio
      $error("mtx_bitclk_div: REF_PER_BIT must be even and at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          bclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID_CNT) bclk_q <= 1'b1;
         end
      end
   end

   assign cell_start_o = (cnt_q == LAST);
   assign mid_o        = (cnt_q == MID_CNT);
   assign first_half_o = (cnt_q < HALF_CNT);
   assign bit_clk_o    = bclk_q;

   a_r2_bitclk_low_at_start : assert property (@(posedge clk) disable iff (!rst_n)
      cell_start_o |=> (!bit_clk_o && first_half_o));

   a_r2_bitclk_high_at_mid : assert property (@(posedge clk) disable iff (!rst_n)
      mid_o |=> (bit_clk_o && !first_half_o));

endmodule

// File: rtl/mtx_cell_sync.sv
module mtx_cell_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic cell_start_i,
   input  logic en_i,
   input  logic data_i,
   input  logic sel_i,
   output logic act_o,
   output logic data_o,
   output logic sel_o
);
   logic act_q, dat_q, sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         dat_q <= 1'b0;
         sel_q <= 1'b0;
      end else if (cell_start_i) begin
         act_q <= en_i;
         dat_q <= data_i;
         sel_q <= sel_i;
      end
   end

   assign act_o  = act_q;
   assign data_o = dat_q;
   assign sel_o  = sel_q;

   a_r5_en_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !cell_start_i |=> $stable(act_o));

   a_r5_data_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !cell_start_i |=> $stable(data_o));

   a_r9_sel_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !cell_start_i |=> $stable(sel_o));

endmodule

// File: rtl/mtx_cell_encoder.sv
module mtx_cell_encoder
   import mtx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      act_i,
   input  logic      data_i,
   input  logic      sel_i,
   input  logic      first_half_i,
   input  logic      mid_i,
   output mtx_line_t line_o
);
   always_comb begin
      if (act_i) line_o = mtx_half_level(data_i, first_half_i);
      else       line_o = mtx_idle_level(sel_i);
   end

   // R3: every active cell flips the positive leg at mid-cell.
   a_r3_mid_transition : assert property (@(posedge clk) disable iff (!rst_n)
      (mid_i && act_i) |=> (line_o.p != $past(line_o.p)));

   // R8: a held-high idle stays put while idle and select are unchanged.
   a_r8_idle_steady : assert property (@(posedge clk) disable iff (!rst_n)
      (!act_i && sel_i) |=> (!act_i && sel_i) |-> $stable(line_o));

endmodule

// File: rtl/manchester_tx_enc.sv
module manchester_tx_enc #(
   parameter int REF_PER_BIT = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_data,
   input  logic idle_hi_sel,
   output logic line_p,
   output logic line_n,
   output logic bit_clk
);
   import mtx_pkg::*;

   logic      cell_start, mid, first_half;
   logic      act, dat, sel;
   mtx_line_t enc;

   mtx_bitclk_div #(.REF_PER_BIT(REF_PER_BIT)) u_div (
      .clk          (clk_ref),
      .rst_n        (rst_n),
      .cell_start_o (cell_start),
      .mid_o        (mid),
      .first_half_o (first_half),
      .bit_clk_o    (bit_clk)
   );

   mtx_cell_sync u_sync (
      .clk          (clk_ref),
      .rst_n        (rst_n),
      .cell_start_i (cell_start),
      .en_i         (tx_en),
      .data_i       (tx_data),
      .sel_i        (idle_hi_sel),
      .act_o        (act),
      .data_o       (dat),
      .sel_o        (sel)
   );

   mtx_cell_encoder u_enc (
      .clk          (clk_ref),
      .rst_n        (rst_n),
      .act_i        (act),
      .data_i       (dat),
      .sel_i        (sel),
      .first_half_i (first_half),
      .mid_i        (mid),
      .line_o       (enc)
   );

   if (OUT_REG) begin : g_out_reg
      mtx_line_t out_q;
      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) out_q <= '0;
         else        out_q <= enc;
      end
      assign line_p = out_q.p;
      assign line_n = out_q.n;
   end else begin : g_out_comb
      assign line_p = enc.p;
      assign line_n = enc.n;
   end

   // R4: the legs never sit at the same level while a cell is being sent.
   a_r4_legs_opposite : assert property (@(posedge clk_ref) disable iff (!rst_n)
      (act && !OUT_REG) |-> (line_p != line_n));

endmodule

// File: tb/manchester_tx_enc_tb.sv
module manchester_tx_enc_tb;

   logic clk_ref = 1'b0;
   logic rst_n   = 1'b0;
   logic tx_en   = 1'b0;
   logic tx_data = 1'b0;
   logic idle_hi_sel = 1'b0;
   logic line_p, line_n, bit_clk;

   int total = 0;
   int bad   = 0;

   always #2.5 clk_ref = ~clk_ref;

   manchester_tx_enc u_dut (
      .clk_ref     (clk_ref),
      .rst_n       (rst_n),
      .tx_en       (tx_en),
      .tx_data     (tx_data),
      .idle_hi_sel (idle_hi_sel),
      .line_p      (line_p),
      .line_n      (line_n),
      .bit_clk     (bit_clk)
   );

   task automatic chk(input string req, input string what,
                      input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual={p,n,bclk}=%b expected=%b", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] obs();
      return {line_p, line_n, bit_clk};
   endfunction

   // Move to a negative edge in the second half of a cell.
   task automatic to_second_half();
      @(negedge clk_ref);
      while (bit_clk !== 1'b1) @(negedge clk_ref);
   endtask

   // Called in a second half; sends one bit, returns in its second half.
   task automatic send_bit(input logic b, input string req);
      tx_en = 1'b1;
      tx_data = b;
      @(negedge clk_ref);
      chk(req, "first half", obs(), {~b, b, 1'b0});
      @(negedge clk_ref);
      chk(req, "second half", obs(), {b, ~b, 1'b1});
   endtask

   task automatic t_reset();
      #12;
      chk("R1", "in reset", obs(), 3'b000);
      @(negedge clk_ref);
      rst_n = 1'b1;
   endtask

   task automatic t_bitclk();
      logic prev;
      to_second_half();
      prev = bit_clk;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk_ref);
         chk("R2", "bit clock toggles each half cell", {2'b00, bit_clk}, {2'b00, ~prev});
         prev = bit_clk;
      end
   endtask

   task automatic t_patterns();
      to_second_half();
      for (int i = 0; i < 4; i++) send_bit(i[0] ? 1'b0 : 1'b1, "R3 R4 alternating");
      for (int i = 0; i < 3; i++) send_bit(1'b0, "R3 zeros");
      for (int i = 0; i < 3; i++) send_bit(1'b1, "R3 ones");
      tx_en = 1'b0;
      @(negedge clk_ref);
      chk("R7", "idle low after traffic", obs(), 3'b000);
      @(negedge clk_ref);
      chk("R7", "idle low second half", obs(), 3'b001);
   endtask

   task automatic t_mid_cell_changes();
      to_second_half();
      tx_en = 1'b1;
      tx_data = 1'b0;
      @(negedge clk_ref);
      chk("R5", "bit 0 first half", obs(), 3'b100);
      tx_en = 1'b0;
      tx_data = 1'b1;
      @(negedge clk_ref);
      chk("R6", "bit completes after enable drop", obs(), 3'b011);
      @(negedge clk_ref);
      chk("R6", "idle after completed bit", obs(), 3'b000);
      // enable raised mid-cell must wait for the boundary
      tx_en = 1'b1;
      tx_data = 1'b1;
      @(negedge clk_ref);
      chk("R5", "mid-cell enable ignored", obs(), 3'b001);
      @(negedge clk_ref);
      chk("R5", "enable taken at boundary", obs(), 3'b010);
      tx_en = 1'b0;
      @(negedge clk_ref);
      @(negedge clk_ref);
   endtask

   task automatic t_idle_high();
      to_second_half();
      tx_en = 1'b0;
      idle_hi_sel = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk_ref);
         chk("R8", "idle high held", {line_p, line_n, 1'b0}, 3'b100);
      end
      // selection changed inside an idle cell: applies next cell
      to_second_half();
      @(negedge clk_ref);
      idle_hi_sel = 1'b0;
      @(negedge clk_ref);
      chk("R9", "select change waits for boundary", obs(), 3'b101);
      @(negedge clk_ref);
      chk("R9", "select applied at next cell", obs(), 3'b000);
   endtask

   task automatic t_sel_during_traffic();
      to_second_half();
      idle_hi_sel = 1'b1;
      send_bit(1'b0, "R9 sel high during traffic");
      idle_hi_sel = 1'b0;
      send_bit(1'b1, "R9 sel low during traffic");
      idle_hi_sel = 1'b1;
      send_bit(1'b1, "R9 sel high again");
      tx_en = 1'b0;
      @(negedge clk_ref);
      chk("R8", "idle high after traffic", obs(), 3'b100);
      idle_hi_sel = 1'b0;
      @(negedge clk_ref);
      @(negedge clk_ref);
      chk("R7", "idle low restored", obs(), 3'b000);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #500000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      t_reset();
      t_bitclk();
      t_patterns();
      t_mid_cell_changes();
      t_idle_high();
      t_sel_during_traffic();
      repeat (4) @(negedge clk_ref);
      finish_run();
   end

endmodule